// File: doc/BRIEF.md
# Loadable Burst Address Counter

This block generates the internal address of one port of a synchronous RAM. In every cycle it settles on the address the memory uses for that cycle's access. It picks from four sources: zero, an external address, the previous address plus one, or the previous address unchanged. At the rising clock edge it keeps a registered copy of that address. The next cycle uses the copy as its base for stepping or holding.

Three active-low controls select the source. Their priority is fixed: clear first, then load, then step. If none of them is asserted, the address holds. The chosen address is used in the same cycle, so a clear, load or step never costs a dead cycle. A host can burst through consecutive words by loading once and then stepping. It can also re-load on every cycle for random access, or stall a burst by releasing the step control. The block has no chip-select or byte-lane inputs, so deselecting the port can never stop the counter. The port carries no data stream, so every pin is a plain level with no valid/ready handshake.

Top module: `burst_addr_counter`

## Requirements
- R1: While `rst_n` is low, `held_addr` is 0. With all three controls high, `cur_addr` is also 0.
- R2: When `clr_n` is low, `cur_addr` is 0 in that cycle, whatever `strobe_n`, `adv_n` and `ext_addr` are.
- R3: When `clr_n` is high and `strobe_n` is low, `cur_addr` equals `ext_addr` in that cycle.
- R4: When `clr_n` and `strobe_n` are high and `adv_n` is low, `cur_addr` equals `held_addr` plus one.
- R5: When all three controls are high, `cur_addr` equals `held_addr`.
- R6: Stepping from address DEPTH-1 gives address 0.
- R7: After each rising edge out of reset, `held_addr` equals the `cur_addr` of the cycle before.
- R8: Holding `strobe_n` low on consecutive cycles gives a new, unrelated address in each cycle.
- R9: A load takes priority over a step when `strobe_n` and `adv_n` are both low.
- R10: While `strobe_n` is high, `ext_addr` has no effect on `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the held address |
| ext_addr | input | ADDR_W | Address taken when a load is selected |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| adv_n | input | 1 | Active-low step to the next address |
| clr_n | input | 1 | Active-low clear to address 0; highest priority |
| cur_addr | output | ADDR_W | Address used by the access in the current cycle |
| held_addr | output | ADDR_W | Registered address of the previous cycle |

## Verification
The bench builds the block with its defaults: ADDR_W = 13 and DEPTH = 8192. With these values the power-of-two wrap variant is the one elaborated. A single load of 8191 followed by one step reaches the top-address wrap within a few cycles. Random-looking loads spread across the full 13-bit range, together with conflicting control combinations, exercise every branch of the priority order.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } bac_op_e;

endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic    clr_n,
  input  logic    strobe_n,
  input  logic    adv_n,
  output bac_op_e op
);

  always_comb begin
    if (!clr_n)         op = OP_CLEAR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!adv_n)    op = OP_STEP;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/bac_step.sv
module bac_step #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8192
) (
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] next
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam bit POW2 = (DEPTH == (1 << ADDR_W));

  generate
    if (POW2) begin : g_natural
      always_comb next = base + 1'b1;
    end else begin : g_compare
      always_comb next = (base >= LAST) ? '0 : base + 1'b1;
    end
  endgenerate

  // R6: stepping off the top address lands on zero
  always_comb begin
    if (base == LAST) begin
      p_wrap_r6: assert (next == '0);
    end
  end

endmodule

// File: rtl/bac_select.sv
module bac_select
  import bac_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  bac_op_e           op,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] stepped,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    unique case (op)
      OP_CLEAR: addr = '0;
      OP_LOAD:  addr = ext_addr;
      OP_STEP:  addr = stepped;
      default:  addr = base;
    endcase
  end

endmodule

// File: rtl/bac_hold_reg.sv
module bac_hold_reg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1: held address is zero throughout reset
  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> q == '0);

  // R7: register follows its input one cycle later
  p_held_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d));

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              adv_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] held_addr
);

  bac_op_e           op;
  logic [ADDR_W-1:0] stepped;

  bac_decode u_decode (
    .clr_n    (clr_n),
    .strobe_n (strobe_n),
    .adv_n    (adv_n),
    .op       (op)
  );

  bac_step #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_step (
    .base (held_addr),
    .next (stepped)
  );

  bac_select #(.ADDR_W(ADDR_W)) u_select (
    .op       (op),
    .ext_addr (ext_addr),
    .stepped  (stepped),
    .base     (held_addr),
    .addr     (cur_addr)
  );

  bac_hold_reg #(.ADDR_W(ADDR_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cur_addr),
    .q     (held_addr)
  );

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  // R2: clear wins over everything
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> cur_addr == '0);

  // R3 / R9: load uses the external address, even with a step request
  p_load_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !strobe_n) |-> cur_addr == ext_addr);

  // R4: step is previous plus one away from the top
  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && strobe_n && !adv_n && held_addr != TOP)
      |-> cur_addr == held_addr + 1'b1);

  // R6: step from the top address gives zero
  p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && strobe_n && !adv_n && held_addr == TOP) |-> cur_addr == '0);

  // R5 / R10: idle controls reuse the held address
  p_hold_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && strobe_n && adv_n) |-> cur_addr == held_addr);

endmodule

// File: tb/burst_addr_counter_bench.sv
module burst_addr_counter_bench;

  localparam int AW    = 13;
  localparam int DEPTH = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] held_addr;

  always #2 clk = ~clk;

  burst_addr_counter #(.ADDR_W(AW), .DEPTH(DEPTH)) u_burst_addr_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .adv_n     (adv_n),
    .clr_n     (clr_n),
    .cur_addr  (cur_addr),
    .held_addr (held_addr)
  );

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 0;

  int    q_cur[$];
  int    q_held[$];
  string q_tag[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: set controls after the falling edge, push expected values
  task automatic drive(input int a, input bit s_n, input bit a_n, input bit c_n,
                       input string tag);
    int nxt;
    @(negedge clk);
    ext_addr = AW'(a);
    strobe_n = s_n;
    adv_n    = a_n;
    clr_n    = c_n;
    if (!c_n)      nxt = 0;
    else if (!s_n) nxt = a % DEPTH;
    else if (!a_n) nxt = (model + 1) % DEPTH;
    else           nxt = model;
    q_cur.push_back(nxt);
    q_held.push_back(model);
    q_tag.push_back(tag);
    model = nxt;
  endtask

  // monitor: compare shortly after the driver's edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_cur.size() > 0) begin
        string t;
        int ec, eh;
        t  = q_tag.pop_front();
        ec = q_cur.pop_front();
        eh = q_held.pop_front();
        check({t, " cur"}, int'(cur_addr), ec);
        check({"R7 held after ", t}, int'(held_addr), eh);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset held", int'(held_addr), 0);
        check("R1 reset cur", int'(cur_addr), 0);
        rst_n = 1'b1;
        drive(13'h0100, 0, 1, 1, "R3 load");
        drive(13'h1FFF, 1, 0, 1, "R4 step");
        drive(13'h0000, 1, 0, 1, "R4 step");
        drive(13'h0ABC, 1, 0, 1, "R4 step");
        drive(13'h1ABC, 1, 1, 1, "R10 ext ignored");
        drive(13'h0555, 1, 1, 1, "R5 hold");
        drive(13'h0050, 0, 0, 1, "R9 load beats step");
        drive(13'h0777, 0, 0, 0, "R2 clear beats load and step");
        drive(13'h0300, 1, 0, 1, "R4 step from zero");
        drive(13'h1FFF, 0, 1, 1, "R3 load top");
        drive(13'h0042, 1, 0, 1, "R6 wrap");
        drive(13'h0042, 1, 0, 1, "R4 step after wrap");
        drive(13'h0AAA, 0, 1, 1, "R8 load a");
        drive(13'h0123, 0, 1, 1, "R8 load b");
        drive(13'h1F00, 0, 1, 1, "R8 load c");
        drive(13'h0011, 1, 0, 0, "R2 clear beats step");
        drive(13'h0999, 1, 1, 1, "R5 hold zero");
        drive(13'h1234, 1, 1, 0, "R2 clear idle");
        drive(13'h0000, 1, 1, 1, "R5 hold end");
        repeat (3) @(negedge clk);
        done = 1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule